// File: doc/BRIEF.md
# Baud Tick Divider with Banked Divisor Latches

The block turns a fixed 12.288 MHz reference clock (a 61.44 MHz source divided by five) into a one-cycle tick that runs at sixteen times the serial bit rate. The divisor is found as reference ÷ (16 × baud). A receive or transmit shifter elsewhere samples or shifts on that tick.

The 16-bit divisor is split across two byte latches, one for the low byte and one for the high byte. Both sit on a small byte-wide register bus. Their addresses are shared with the data and interrupt-enable registers, and the bank-select bit in the line control register decides which of the two sets a given access reaches. Writing either divisor byte loads the down-counter with the new 16-bit value in the same cycle, so the tick spacing changes at once.

A divisor of zero is not a supported rate. With zero loaded, the block stays silent and the counter holds its value. Out of reset the divisor is zero, so no ticks appear until software programs the latches.

Top module: `baud_div_gen`

## Requirements
- R1: After reset the line control byte and both divisor bytes read back as 0x00, and `tick_o` stays low.
- R2: Address 3 holds the line control byte. It can be read and written at any time, and its bit 7 is the bank-select bit.
- R3: While bit 7 is 1, address 0 reads and writes the low divisor byte and address 1 reads and writes the high divisor byte.
- R4: While bit 7 is 0, writes to addresses 0 and 1 leave both divisor bytes unchanged, and reads of those addresses return 0x00.
- R5: For a divisor D ≥ 2, `tick_o` is a single-cycle pulse that repeats exactly every D clock cycles.
- R6: A divisor-byte write reloads the counter with the full new divisor on the same clock edge. The first tick follows D−1 cycles after that edge, whatever count was in progress.
- R7: With a divisor of 1, `tick_o` is high on every cycle.
- R8: With a divisor of 0, `tick_o` stays low and the counter holds.
- R9: The divisor is {high byte, low byte} taken as an unsigned 16-bit value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Reference clock, 12.288 MHz |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 3 | Register address |
| wdata_i | input | 8 | Write data |
| we_i | input | 1 | Write strobe, one cycle per write |
| rdata_o | output | 8 | Read data for `addr_i`, combinational |
| tick_o | output | 1 | 16× baud tick |

## Verification
The properties assume that a write strobe is held for one clock with a stable address and data. They also assume that the bank-select bit seen during a divisor write is the value already in the register, never one written in the same cycle. The stimulus issues one write per cycle, then drops the strobe before the next bus operation. It sets the select bit in a separate write before any divisor access. The tick checks look only at windows that start at the final divisor write, because a low byte combined with a stale high byte can briefly load a transient divisor.

// File: rtl/baud_pkg.sv
package baud_pkg;
  localparam int ADDR_DIV_LO   = 0;
  localparam int ADDR_DIV_HI   = 1;
  localparam int ADDR_LINE_CTL = 3;
  localparam int BANK_SEL_BIT  = 7;

  typedef enum logic [1:0] {
    SEL_NONE,
    SEL_DIV_LO,
    SEL_DIV_HI,
    SEL_LINE_CTL
  } reg_sel_e;
endpackage

// File: rtl/baud_regs.sv
module baud_regs
  import baud_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 3,
  localparam int DIV_W = 2 * DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              we_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [DATA_W-1:0] lcr_o,
  output logic [DIV_W-1:0]  div_o,
  output logic              load_o,
  output logic [DIV_W-1:0]  load_val_o
);
  logic [DATA_W-1:0] lcr_q, div_lo_q, div_hi_q;
  logic              bank_sel;
  reg_sel_e          sel;

  assign bank_sel = lcr_q[BANK_SEL_BIT];

  always_comb begin
    sel = SEL_NONE;
    if (addr_i == ADDR_W'(ADDR_LINE_CTL))                   sel = SEL_LINE_CTL;
    else if (bank_sel && addr_i == ADDR_W'(ADDR_DIV_LO))    sel = SEL_DIV_LO;
    else if (bank_sel && addr_i == ADDR_W'(ADDR_DIV_HI))    sel = SEL_DIV_HI;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lcr_q    <= '0;
      div_lo_q <= '0;
      div_hi_q <= '0;
    end else if (we_i) begin
      unique case (sel)
        SEL_LINE_CTL: lcr_q    <= wdata_i;
        SEL_DIV_LO:   div_lo_q <= wdata_i;
        SEL_DIV_HI:   div_hi_q <= wdata_i;
        default: ;
      endcase
    end
  end

  // Counter reload takes the merged value that the latches will hold after this edge
  assign load_o     = we_i && (sel == SEL_DIV_LO || sel == SEL_DIV_HI);
  assign load_val_o = (sel == SEL_DIV_LO) ? {div_hi_q, wdata_i} : {wdata_i, div_lo_q};

  always_comb begin
    unique case (sel)
      SEL_LINE_CTL: rdata_o = lcr_q;
      SEL_DIV_LO:   rdata_o = div_lo_q;
      SEL_DIV_HI:   rdata_o = div_hi_q;
      default:      rdata_o = '0;
    endcase
  end

  assign lcr_o = lcr_q;
  assign div_o = {div_hi_q, div_lo_q};
endmodule

// File: rtl/baud_counter.sv
module baud_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] div_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             tick_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             div_zero, at_end;

  assign div_zero = (div_i == '0);
  assign at_end   = (cnt_q <= CNT_W'(1));

  always_comb begin
    if (load_i)        cnt_d = load_val_i;
    else if (div_zero) cnt_d = cnt_q;
    else if (at_end)   cnt_d = div_i;
    else               cnt_d = cnt_q - CNT_W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign tick_o = !div_zero && (cnt_q == CNT_W'(1));
  assign cnt_o  = cnt_q;
endmodule

// File: rtl/baud_div_gen.sv
module baud_div_gen #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              we_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              tick_o
);
  localparam int DIV_W = 2 * DATA_W;

  logic [DATA_W-1:0] lcr;
  logic [DIV_W-1:0]  divisor, load_val, cnt;
  logic              load;

  baud_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) i_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .addr_i     (addr_i),
    .wdata_i    (wdata_i),
    .we_i       (we_i),
    .rdata_o    (rdata_o),
    .lcr_o      (lcr),
    .div_o      (divisor),
    .load_o     (load),
    .load_val_o (load_val)
  );

  baud_counter #(.CNT_W(DIV_W)) i_counter (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .div_i      (divisor),
    .load_i     (load),
    .load_val_i (load_val),
    .cnt_o      (cnt),
    .tick_o     (tick_o)
  );
endmodule

// File: rtl/baud_gen_chk.sv
module baud_gen_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic [2:0]  addr_i,
  input logic [7:0]  wdata_i,
  input logic        we_i,
  input logic        tick_o,
  input logic [7:0]  lcr_i,
  input logic [15:0] div_i,
  input logic [15:0] cnt_i
);
  a_r2_line_ctl_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == 3'd3) |=> lcr_i == $past(wdata_i));

  a_r4_bank_locked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && !lcr_i[7] && addr_i < 3'd2) |=> $stable(div_i));

  a_r6_lo_reload: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && lcr_i[7] && addr_i == 3'd0) |=> cnt_i[7:0] == $past(wdata_i));

  a_r6_hi_reload: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && lcr_i[7] && addr_i == 3'd1) |=> cnt_i[15:8] == $past(wdata_i));

  a_r5_cnt_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (div_i != 16'd0) |-> (cnt_i != 16'd0 && cnt_i <= div_i));

  a_r5_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && div_i > 16'd1 && !we_i) |=> !tick_o);

  a_r7_every_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (div_i == 16'd1) |-> tick_o);

  a_r8_zero_silent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (div_i == 16'd0) |-> !tick_o);

  a_r8_zero_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (div_i == 16'd0 && !we_i) |=> $stable(cnt_i));
endmodule

bind baud_div_gen baud_gen_chk i_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .addr_i  (addr_i),
  .wdata_i (wdata_i),
  .we_i    (we_i),
  .tick_o  (tick_o),
  .lcr_i   (lcr),
  .div_i   (divisor),
  .cnt_i   (cnt)
);

// File: tb/test_baud_div_gen.sv
module test_baud_div_gen;
  localparam int CLK_PERIOD = 10;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [2:0] addr_i = '0;
  logic [7:0] wdata_i = '0;
  logic       we_i = 1'b0;
  logic [7:0] rdata_o;
  logic       tick_o;

  int n_chk = 0, n_fail = 0;
  int cyc = 0;
  int q[$];
  int mon_lo = 0, mon_hi = -1;
  bit mon_on = 0;
  string cur_req = "R5";
  logic exp_tick;

  baud_div_gen i_baud_div_gen (
    .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .wdata_i(wdata_i),
    .we_i(we_i), .rdata_o(rdata_o), .tick_o(tick_o)
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;
  always @(posedge clk_i) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // scoreboard monitor: pops expected tick cycles
  always @(negedge clk_i) begin
    if (mon_on && cyc >= mon_lo && cyc <= mon_hi) begin
      exp_tick = (q.size() > 0 && q[0] == cyc);
      if (exp_tick) void'(q.pop_front());
      check(tick_o == exp_tick, cur_req, int'(tick_o), int'(exp_tick));
    end
  end

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk_i);
    addr_i = a; wdata_i = d; we_i = 1'b1;
    @(posedge clk_i);
    #1 we_i = 1'b0;
  endtask

  task automatic rd_check(input logic [2:0] a, input logic [7:0] exp, input string req);
    @(negedge clk_i);
    addr_i = a;
    #1 check(rdata_o == exp, req, int'(rdata_o), int'(exp));
  endtask

  // driver: programs divisor and pushes expected tick cycles
  task automatic run_div(input int d, input int len, input string req);
    int w;
    mon_on = 0;
    wr(3'd1, 8'(d >> 8));
    wr(3'd0, 8'(d & 255));
    w = cyc;
    q.delete();
    if (d > 0)
      for (int t = w + d - 1; t < w + len; t += d) q.push_back(t);
    cur_req = req;
    mon_lo = w; mon_hi = w + len - 1; mon_on = 1;
    repeat (len) @(negedge clk_i);
    #1;
    check(q.size() == 0, req, q.size(), 0);
    mon_on = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    // R1 reset state
    rd_check(3'd3, 8'h00, "R1");
    for (int i = 0; i < 20; i++) begin
      @(negedge clk_i);
      check(tick_o == 1'b0, "R1", int'(tick_o), 0);
    end
    wr(3'd3, 8'h80);
    rd_check(3'd3, 8'h80, "R2");
    rd_check(3'd0, 8'h00, "R1");
    rd_check(3'd1, 8'h00, "R1");
    // R3 latch access
    wr(3'd0, 8'hA5);
    wr(3'd1, 8'h3C);
    rd_check(3'd0, 8'hA5, "R3");
    rd_check(3'd1, 8'h3C, "R3");
    // R4 bank closed
    wr(3'd3, 8'h03);
    rd_check(3'd3, 8'h03, "R2");
    wr(3'd0, 8'h11);
    wr(3'd1, 8'h22);
    rd_check(3'd0, 8'h00, "R4");
    rd_check(3'd1, 8'h00, "R4");
    wr(3'd3, 8'h80);
    rd_check(3'd0, 8'hA5, "R4");
    rd_check(3'd1, 8'h3C, "R4");
    // tick spacing
    run_div(3, 30, "R5");
    run_div(16, 100, "R5");
    run_div(1, 20, "R7");
    run_div(0, 60, "R8");
    run_div(258, 600, "R9");
    // R6 reload mid-count
    run_div(200, 30, "R6");
    run_div(5, 40, "R6");
    run_div(2, 12, "R6");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule